// File: doc/BRIEF.md
# GPIO Interrupt Capture Controller

This block watches 32 general-purpose input lines and turns activity on them into interrupt requests for a single downstream interrupt line. Each line is brought into the clock domain by a synchroniser. A per-line configuration then picks level or edge detection, the polarity for level detection, the edges of interest for edge detection, and whether a detected edge is latched until software clears it or only passes through for one cycle. The resulting pending bits, masked by per-line enables, are combined into one interrupt output. The index of the pending line with the highest priority is also reported.

Software reaches the block through a small memory-mapped bus: a byte address, a write strobe, 16-bit write data, and combinational 16-bit read data. The 32 lines form a low group (lines 0 to 15) and a high group (lines 16 to 31). Every function has one 16-bit register per group, and bit n of a group register belongs to line n of that group. The asynchronous active-low reset is released through a two-flop synchroniser, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `gpio_irq_capture`

## Requirements
- R1: The register map is as follows, with the low group at the first address of each pair and the high group at the second. Pending 0x08/0x0A, enable 0x0C/0x0E, mode 0x10/0x12, polarity 0x14/0x16, latch 0x18/0x1A, falling 0x20/0x22, rising 0x24/0x26. Every configuration register reads back the last value written to it. The pending registers read the current pending bits. Any other address, and any odd address, reads 0 and ignores writes.
- R2: While reset is active, and right after it, every register reads 0 and `irq_out` and `pend_valid` are low.
- R3: A change on an input line that drives a level-mode pending bit appears in that bit after the third rising clock edge following the change. Two of those edges are spent in the synchroniser.
- R4: With a mode bit of 0 (level), the pending bit follows the synchronised line each cycle: 1 when the line equals the polarity bit (1 means active high, 0 means active low). In level mode the latch bit is ignored, and a write of 1 to the pending bit has no lasting effect.
- R5: With a mode bit of 1 (edge), a synchronised rising transition is detected only if the rising bit is 1, and a falling transition only if the falling bit is 1. With both bits set, both edges are detected. With neither set, no edge is detected.
- R6: In edge mode with a latch bit of 1, a detected edge sets the pending bit. The bit stays set until a 1 is written to it at the pending address, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clearing write, the bit stays set.
- R7: In edge mode with a latch bit of 0, a detected edge makes the pending bit 1 for exactly one cycle.
- R8: `pend_valid` is high when any line has both its pending and enable bits set. `pend_index` then gives the lowest such line number, so any line in the low group wins over every line in the high group. `pend_index` is 0 when `pend_valid` is low.
- R9: `irq_out` is the OR of all 32 (pending AND enable) bits. Clearing an enable bit masks its line without changing the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous input lines |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |
| pend_valid | output | 1 | A masked-in pending line exists |
| pend_index | output | 5 | Number of the highest-priority pending line |

## Verification
The bench counts the synchroniser latency edge by edge. A design with one flop too few or too many would raise the pending bit a cycle early or late. It drives a clearing write in the very cycle that an edge is detected, which catches a design that lets the clear win and drops an event. It writes ones to a pending bit in level mode, where a design that honoured the latch bit or the write would keep a stale value. It also places pending lines in both groups at once, disables the low one, and checks that the index moves to the high one while the masked bit stays pending. A priority encoder scanning in the wrong order, or an enable that cleared the pending state, would report the wrong line or lose the bit.

// File: rtl/gic_pkg.sv
package gic_pkg;

  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    FN_NONE, FN_PEND, FN_EN, FN_MODE, FN_POL, FN_LATCH, FN_FALL, FN_RISE
  } gic_fn_e;

  // Word index (address bits 5:2) selects the function; bit 1 the group.
  function automatic gic_fn_e decode_fn(input logic [ADDR_W-1:0] a);
    gic_fn_e f;
    if (a[0]) begin
      f = FN_NONE;
    end else begin
      case (a[5:2])
        4'd2:    f = FN_PEND;
        4'd3:    f = FN_EN;
        4'd4:    f = FN_MODE;
        4'd5:    f = FN_POL;
        4'd6:    f = FN_LATCH;
        4'd8:    f = FN_FALL;
        4'd9:    f = FN_RISE;
        default: f = FN_NONE;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

endmodule

// File: rtl/gic_half.sv
module gic_half
  import gic_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         wr_en,
  input  gic_fn_e      wr_fn,
  input  gic_fn_e      rd_fn,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] pend,
  output logic [W-1:0] enable,
  output logic [W-1:0] latch_mask,
  output logic [W-1:0] clr_bits
);

  logic [W-1:0] en_q, mode_q, pol_q, latch_q, fall_q, rise_q, pend_q;
  logic [W-1:0] pend_d, edge_ev, lvl_hit, held;
  logic         ld_en, ld_mode, ld_pol, ld_latch, ld_fall, ld_rise;

  // Clock enables for the configuration registers
  always_comb begin
    ld_en    = wr_en && (wr_fn == FN_EN);
    ld_mode  = wr_en && (wr_fn == FN_MODE);
    ld_pol   = wr_en && (wr_fn == FN_POL);
    ld_latch = wr_en && (wr_fn == FN_LATCH);
    ld_fall  = wr_en && (wr_fn == FN_FALL);
    ld_rise  = wr_en && (wr_fn == FN_RISE);
    clr_bits = (wr_en && (wr_fn == FN_PEND)) ? wdata : '0;
  end

  // Next-state of the pending bits
  always_comb begin
    edge_ev = mode_q & ((rise_q & cur & ~prev) | (fall_q & ~cur & prev));
    lvl_hit = ~(cur ^ pol_q);
    held    = mode_q & latch_q;
    pend_d  = (held & ((pend_q & ~clr_bits) | edge_ev))
            | (~held & mode_q & edge_ev)
            | (~mode_q & lvl_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      latch_q <= '0;
      fall_q  <= '0;
      rise_q  <= '0;
      pend_q  <= '0;
    end else begin
      if (ld_en)    en_q    <= wdata;
      if (ld_mode)  mode_q  <= wdata;
      if (ld_pol)   pol_q   <= wdata;
      if (ld_latch) latch_q <= wdata;
      if (ld_fall)  fall_q  <= wdata;
      if (ld_rise)  rise_q  <= wdata;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (rd_fn)
      FN_PEND:  rd_data = pend_q;
      FN_EN:    rd_data = en_q;
      FN_MODE:  rd_data = mode_q;
      FN_POL:   rd_data = pol_q;
      FN_LATCH: rd_data = latch_q;
      FN_FALL:  rd_data = fall_q;
      FN_RISE:  rd_data = rise_q;
      default:  rd_data = '0;
    endcase
  end

  assign pend       = pend_q;
  assign enable     = en_q;
  assign latch_mask = held;

endmodule

// File: rtl/gic_prio.sv
module gic_prio #(
  parameter  int N     = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top down so the lowest set bit is the last one kept.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture
  import gic_pkg::*;
#(
  parameter  int HALF_W = 16,
  localparam int PINS   = 2 * HALF_W,
  localparam int IDX_W  = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              pend_valid,
  output logic [IDX_W-1:0]  pend_index
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [PINS-1:0]   sync_cur, sync_prev;
  logic [PINS-1:0]   pend_vec, en_vec, latch_vec, clr_vec, active_vec;
  logic [HALF_W-1:0] rd_h [2];
  gic_fn_e           acc_fn;

  // Reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gic_sync #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .raw  (pin_in),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  assign acc_fn = decode_fn(bus_addr);

  for (genvar h = 0; h < 2; h++) begin : g_half
    gic_half #(.W(HALF_W)) u_half (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cur       (sync_cur[h*HALF_W +: HALF_W]),
      .prev      (sync_prev[h*HALF_W +: HALF_W]),
      .wr_en     (bus_we && (bus_addr[1] == 1'(h))),
      .wr_fn     (acc_fn),
      .rd_fn     (acc_fn),
      .wdata     (bus_wdata),
      .rd_data   (rd_h[h]),
      .pend      (pend_vec[h*HALF_W +: HALF_W]),
      .enable    (en_vec[h*HALF_W +: HALF_W]),
      .latch_mask(latch_vec[h*HALF_W +: HALF_W]),
      .clr_bits  (clr_vec[h*HALF_W +: HALF_W])
    );
  end

  assign bus_rdata  = (acc_fn == FN_NONE) ? '0 : rd_h[bus_addr[1]];
  assign active_vec = pend_vec & en_vec;
  assign irq_out    = |active_vec;

  gic_prio #(.N(PINS)) u_prio (
    .req  (active_vec),
    .valid(pend_valid),
    .idx  (pend_index)
  );

endmodule

// File: rtl/gic_checker.sv
module gic_checker #(
  parameter  int PINS  = 32,
  localparam int IDX_W = $clog2(PINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             pend_valid,
  input logic [IDX_W-1:0] pend_index,
  input logic [PINS-1:0]  active_vec,
  input logic [PINS-1:0]  pend_vec,
  input logic [PINS-1:0]  latch_vec,
  input logic [PINS-1:0]  clr_vec
);

  AST_IRQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == pend_valid); // R9

  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> pend_index == '0); // R8

  AST_IDX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> active_vec[pend_index]); // R8

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (active_vec & ((PINS'(1) << pend_index) - PINS'(1))) == '0); // R8

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_vec) & $past(latch_vec) & ~$past(clr_vec)) & ~pend_vec) == '0); // R6

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_out); // R2

endmodule

bind gpio_irq_capture gic_checker #(.PINS(PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_out   (irq_out),
  .pend_valid(pend_valid),
  .pend_index(pend_index),
  .active_vec(active_vec),
  .pend_vec  (pend_vec),
  .latch_vec (latch_vec),
  .clr_vec   (clr_vec)
);

// File: tb/sim_gpio_irq_capture.sv
`timescale 1ns/1ps
module sim_gpio_irq_capture;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic [5:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq, valid;
  logic [4:0]  index;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  gpio_irq_capture u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq), .pend_valid(valid),
    .pend_index(index)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_st, m_en, m_ty, m_ac, m_ho, m_fa, m_ri, m_s1, m_s2, m_s3;
  bit        m_r1, m_r2;

  task automatic m_clear();
    m_st = 0; m_en = 0; m_ty = 0; m_ac = 0; m_ho = 0; m_fa = 0; m_ri = 0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  function automatic bit [15:0] m_read(input logic [5:0] a);
    case (a)
      6'h08: return m_st[15:0];  6'h0A: return m_st[31:16];
      6'h0C: return m_en[15:0];  6'h0E: return m_en[31:16];
      6'h10: return m_ty[15:0];  6'h12: return m_ty[31:16];
      6'h14: return m_ac[15:0];  6'h16: return m_ac[31:16];
      6'h18: return m_ho[15:0];  6'h1A: return m_ho[31:16];
      6'h20: return m_fa[15:0];  6'h22: return m_fa[31:16];
      6'h24: return m_ri[15:0];  6'h26: return m_ri[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [31:0] clr, nst;
    bit        e;
    int        best;
    if (!rst_n) begin
      m_clear(); m_r1 = 0; m_r2 = 0;
    end else begin
      if (!m_r2) m_clear();
      else begin
        clr = 0;
        if (we && addr == 6'h08) clr[15:0]  = wdata;
        if (we && addr == 6'h0A) clr[31:16] = wdata;
        for (int i = 0; i < 32; i++) begin
          e = m_ty[i] && ((m_ri[i] && m_s2[i] && !m_s3[i]) || (m_fa[i] && !m_s2[i] && m_s3[i]));
          if (!m_ty[i])     nst[i] = (m_s2[i] == m_ac[i]);
          else if (m_ho[i]) nst[i] = e || (m_st[i] && !clr[i]);
          else              nst[i] = e;
        end
        m_st = nst; m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
        if (we) case (addr)
          6'h0C: m_en[15:0] = wdata;  6'h0E: m_en[31:16] = wdata;
          6'h10: m_ty[15:0] = wdata;  6'h12: m_ty[31:16] = wdata;
          6'h14: m_ac[15:0] = wdata;  6'h16: m_ac[31:16] = wdata;
          6'h18: m_ho[15:0] = wdata;  6'h1A: m_ho[31:16] = wdata;
          6'h20: m_fa[15:0] = wdata;  6'h22: m_fa[31:16] = wdata;
          6'h24: m_ri[15:0] = wdata;  6'h26: m_ri[31:16] = wdata;
          default: ;
        endcase
      end
      m_r2 = m_r1; m_r1 = 1;
    end
    #1;
    if (started && !done) begin
      best = 0;
      for (int i = 31; i >= 0; i--) if (m_st[i] && m_en[i]) best = i;
      chk("R1 readback", {16'h0, rdata}, {16'h0, m_read(addr)});
      chk("R9 irq", {31'h0, irq}, {31'h0, |(m_st & m_en)});
      chk("R8 valid/index", {26'h0, valid, index},
          {26'h0, |(m_st & m_en), 5'((|(m_st & m_en)) ? best : 0)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, {16'h0, rdata}, {16'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [5:0] regs [14] = '{6'h0C, 6'h0E, 6'h10, 6'h12, 6'h14, 6'h16, 6'h18,
                            6'h1A, 6'h20, 6'h22, 6'h24, 6'h26, 6'h08, 6'h0A};

  initial begin
    rst_n = 1'b0; pins = '1; addr = 6'h0C; we = 1'b0; wdata = '0;
    idle(3);
    #1;
    // R2: quiet while in reset
    chk("R2 enable in reset", {16'h0, rdata}, 32'h0);
    chk("R2 irq in reset", {30'h0, irq, valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1; started = 1;
    idle(6);
    for (int k = 0; k < 14; k++) rd_chk("R2 reset value", regs[k], 16'h0);

    // R1: readback of every configuration register, unmapped addresses
    for (int k = 0; k < 12; k++) begin
      wr(regs[k], 16'h1000 * 16'(k) + 16'h0A5 + 16'(k));
      rd_chk("R1 write/read", regs[k], 16'h1000 * 16'(k) + 16'h0A5 + 16'(k));
    end
    wr(6'h1C, 16'hFFFF);
    rd_chk("R1 unmapped", 6'h1C, 16'h0);
    wr(6'h0D, 16'hFFFF);
    rd_chk("R1 odd address", 6'h0D, 16'h0);
    rd_chk("R1 enable untouched by odd write", 6'h0C, 16'h00A5);
    for (int k = 0; k < 12; k++) wr(regs[k], 16'h0);
    idle(4);
    wr(6'h08, 16'hFFFF); wr(6'h0A, 16'hFFFF);
    rd_chk("R4 all idle", 6'h08, 16'h0);

    // R3: three-edge latency, level mode active low
    @(negedge clk); pins[3] = 1'b0; addr = 6'h08;
    @(posedge clk); #1; chk("R3 edge1", {16'h0, rdata}, 32'h0);
    @(posedge clk); #1; chk("R3 edge2", {16'h0, rdata}, 32'h0);
    @(posedge clk); #1; chk("R3 edge3", {16'h0, rdata}, 32'h8);

    // R4: latch bit and write-one ignored in level mode; polarity flip
    wr(6'h18, 16'hFFFF);
    wr(6'h08, 16'h0008);
    rd_chk("R4 w1c no effect", 6'h08, 16'h0008);
    wr(6'h14, 16'h0008);
    rd_chk("R4 polarity high", 6'h08, 16'h0000);
    wr(6'h14, 16'h0000); wr(6'h18, 16'h0000);
    @(negedge clk); pins[3] = 1'b1;
    idle(5);

    // R5: edge selection on pins 0..3
    wr(6'h24, 16'h0005); wr(6'h20, 16'h0006);
    wr(6'h18, 16'h000F); wr(6'h10, 16'h000F);
    wr(6'h08, 16'h000F);
    rd_chk("R5 clean start", 6'h08, 16'h0);
    @(negedge clk); pins[3:0] = 4'h0;
    idle(5);
    rd_chk("R5 falling", 6'h08, 16'h0006);
    wr(6'h08, 16'h000F);
    rd_chk("R5 cleared", 6'h08, 16'h0);
    @(negedge clk); pins[3:0] = 4'hF;
    idle(5);
    rd_chk("R5 rising", 6'h08, 16'h0005);

    // R6: latched, write 0 ignored, write 1 clears, event beats clear
    idle(10);
    rd_chk("R6 still held", 6'h08, 16'h0005);
    wr(6'h08, 16'h0000);
    rd_chk("R6 write zero", 6'h08, 16'h0005);
    wr(6'h08, 16'h0001);
    rd_chk("R6 write one", 6'h08, 16'h0004);
    @(negedge clk); pins[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 6'h08; we = 1'b1; wdata = 16'h0002;
    @(negedge clk); we = 1'b0;
    rd_chk("R6 set wins over clear", 6'h08, 16'h0006);
    wr(6'h08, 16'hFFFF);
    rd_chk("R6 all cleared", 6'h08, 16'h0);

    // R7: pass-through edge is a one-cycle pulse
    wr(6'h18, 16'h000B);
    @(negedge clk); pins[2] = 1'b0; addr = 6'h08;
    @(posedge clk); #1; chk("R7 edge1", {16'h0, rdata}, 32'h0);
    @(posedge clk); #1; chk("R7 edge2", {16'h0, rdata}, 32'h0);
    @(posedge clk); #1; chk("R7 pulse", {16'h0, rdata}, 32'h4);
    @(posedge clk); #1; chk("R7 pulse end", {16'h0, rdata}, 32'h0);

    // R8 / R9: priority across groups and masking
    @(negedge clk); pins[20] = 1'b0; pins[17] = 1'b0;
    idle(4);
    wr(6'h0E, 16'hFFFF);
    rd_chk("R8 high pending", 6'h0A, 16'h0012);
    chk("R8 index high", {26'h0, valid, index}, {26'h0, 1'b1, 5'd17});
    @(negedge clk); pins[9] = 1'b0;
    idle(4);
    wr(6'h0C, 16'h0200);
    @(negedge clk); #1;
    chk("R8 low group first", {26'h0, valid, index}, {26'h0, 1'b1, 5'd9});
    wr(6'h0C, 16'h0000);
    rd_chk("R9 mask keeps pending", 6'h08, 16'h0200);
    chk("R9 masked index moves", {26'h0, valid, index}, {26'h0, 1'b1, 5'd17});
    wr(6'h0E, 16'h0000);
    @(negedge clk); #1;
    chk("R9 irq off", {30'h0, irq, valid}, 32'h0);

    // Mixed random traffic checked against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) pins = pins ^ (32'h1 << $urandom_range(31));
      addr  = regs[$urandom_range(13)] ^ (($urandom_range(15) == 0) ? 6'h01 : 6'h00);
      we    = ($urandom_range(5) == 0);
      wdata = 16'($urandom);
    end
    @(negedge clk); we = 1'b0;
    idle(3);
    finish_run();
  end

endmodule